// File: doc/BRIEF.md
# Byte-Bus Interface Unit with Prefetch Arbitration

This block drives an 8-bit external bus on behalf of an execution unit. Every bus transfer runs through four clock phases, T1 to T4. When a slot boundary comes up, the unit decides what the next slot does. It can run an execution-unit byte transfer, run an instruction prefetch into a four-byte queue, or leave the bus idle for a short while.

Execution-unit requests normally win over prefetches. A sticky pending flag keeps the queue from starving. The flag is raised during any execution-unit transfer that finds bytes already waiting in the queue. It forces the following slot onto the prefetch side: a fetch if the queue has room, or a three-clock idle gap if the queue is full. A word access is split into a low-byte cycle and a high-byte cycle, and nothing can be scheduled between the two.

The execution unit holds its request level until it sees the done pulse, and it drops or replaces the request in that same clock. It reads instruction bytes from the head of the queue. A flush input empties the queue and reloads the prefetch address.

Top module: `busunit_arbiter`

## Requirements
- R1: `bus_state` encodes the phase as 0 for idle and 1, 2, 3, 4 for T1 to T4. Every transfer walks T1, T2, T3, T4 on consecutive clocks. `bus_rd` or `bus_wr` is high in T2 and T3 only. The bus is idle during reset.
- R2: When a slot boundary sees an execution-unit request and the pending flag is clear, that request starts at T1 in the next clock, ahead of any prefetch.
- R3: An execution-unit byte cycle whose T3 finds the queue non-empty forces the next slot to be a prefetch when the queue has room. A request held across that transfer is then served in the slot after the prefetch, so the two execution-unit T2 phases are 8 clocks apart.
- R4: A forced slot that finds the queue full idles the bus for exactly 3 clocks. Two back-to-back byte reads with a full queue therefore have T2 phases 7 clocks apart, with no prefetch between them.
- R5: With no request and a full queue, the unit idles one clock at a time and re-arbitrates on every clock.
- R6: A word access runs the low byte at `req_addr` and then the high byte at `req_addr`+1, with carry across the full address width. The two T2 phases are 4 clocks apart.
- R7: With no requests, prefetches run back to back at addresses increasing by 1 until the queue holds 4 bytes. After reset the prefetch address is 0.
- R8: `req_done` is high for exactly one clock, in the clock after the final T4. On reads, `req_rdata` holds {high byte, low byte}; a byte read returns zero in bits 15:8.
- R9: A `flush` seen at a slot boundary empties the queue, clears the pending flag and reloads the prefetch address from `flush_addr`. One idle clock follows, then fetching resumes. A flush pulse that falls inside a transfer is ignored.
- R10: The queue returns bytes in fetch order at `q_byte` while `q_valid` is high. A pop on an empty queue is ignored, even when a prefetch byte is written in the same clock.
- R11: A prefetch cycle never raises the pending flag. A request present at a prefetch's final T4 starts at once, even when the queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Execution-unit request level |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr | input | AW | Request address |
| req_wdata | input | 16 | Write data, low byte first on the bus |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Read result |
| q_pop | input | 1 | Consume the queue head |
| q_valid | output | 1 | Queue holds at least one byte |
| q_byte | output | 8 | Queue head byte |
| flush | input | 1 | Clear queue and reload prefetch address |
| flush_addr | input | AW | New prefetch address |
| bus_addr | output | AW | Bus address for the current transfer |
| bus_dout | output | 8 | Bus write data |
| bus_din | input | 8 | Bus read data, sampled at the end of T3 |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_state | output | 3 | Phase indicator |

## Verification
The clock that ends an execution-unit transfer is both a slot boundary and the clock in which its request is still asserted. That makes it the point where the stale request, the pending flag and the queue fill level meet. The bench holds a request across done under three queue conditions: empty, partly filled and full. It then judges the outcome from the logged T2 spacing (8, 7 or an immediate start) and from what lies between the two transfers. Queue pop and prefetch push are also made to meet: the bench drains the queue so that the last pop lands on the clock before a fetched byte arrives, then pops once more on the empty queue. It then requires the new byte to appear at the head with the valid flag set.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    CY_PF   = 2'd0,
    CY_EULO = 2'd1,
    CY_EUHI = 2'd2
  } cyc_e;

  localparam logic [1:0] FORCED_IDLE_LAST = 2'd2;
endpackage

// File: rtl/bpa_queue.sv
module bpa_queue #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [7:0]    push_data_i,
  input  logic          pop_i,
  output logic [7:0]    head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PW'(1);
  endfunction

  assign do_push = push_i && !clr_i && (cnt_q != FULL_CNT);
  assign do_pop  = pop_i && !clr_i && (cnt_q != '0);

  always_comb begin
    wr_d  = do_push ? ptr_inc(wr_q) : wr_q;
    rd_d  = do_pop ? ptr_inc(rd_q) : rd_q;
    cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    if (clr_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data_i;
  end

  assign head_o  = mem[rd_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == FULL_CNT);

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  a_r10_pop_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && cnt_q == '0 && !push_i && !clr_i) |=> (cnt_q == '0));
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/bpa_seq.sv
module bpa_seq
  import bpa_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic          req_word_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [15:0]   req_wdata_i,
  output logic          req_done_o,
  output logic [15:0]   req_rdata_o,
  input  logic          flush_i,
  input  logic [AW-1:0] flush_addr_i,
  input  logic [CW-1:0] q_count_i,
  input  logic          q_full_i,
  output logic          q_push_o,
  output logic          q_clr_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [7:0]    bus_dout_o,
  input  logic [7:0]    bus_din_i,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic [2:0]    bus_state_o
);
  phase_e        ph_q, ph_d;
  cyc_e          cyc_q, cyc_d;
  logic [1:0]    idle_q, idle_d;
  logic          flag_q, flag_d;
  logic [AW-1:0] pfa_q, pfa_d, addr_q, addr_d;
  logic          wr_q, wr_d, word_q, word_d, done_q, done_d;
  logic [15:0]   wdat_q, wdat_d, rdat_q, rdat_d;
  logic          boundary, hi_next, eu_final, req_seen, strobe;

  assign boundary = (ph_q == PH_T4) || (ph_q == PH_IDLE && idle_q == 2'd0);
  assign hi_next  = (ph_q == PH_T4) && (cyc_q == CY_EULO) && word_q;
  assign eu_final = (cyc_q != CY_PF) && (!word_q || cyc_q == CY_EUHI);
  // a request still asserted at the final T4 of its own transfer is stale
  assign req_seen = req_valid_i && !((ph_q == PH_T4) && (cyc_q != CY_PF));

  always_comb begin
    ph_d = ph_q;  cyc_d = cyc_q;  idle_d = idle_q;  flag_d = flag_q;
    pfa_d = pfa_q;  addr_d = addr_q;  wr_d = wr_q;  word_d = word_q;
    wdat_d = wdat_q;  rdat_d = rdat_q;  q_clr_o = 1'b0;
    done_d = (ph_q == PH_T4) && eu_final;
    unique case (ph_q)
      PH_T1: ph_d = PH_T2;
      PH_T2: ph_d = PH_T3;
      PH_T3: begin
        ph_d = PH_T4;
        if (cyc_q == CY_PF) begin
          pfa_d = pfa_q + AW'(1);
        end else begin
          if (q_count_i != '0) flag_d = 1'b1;
          if (!wr_q) begin
            if (cyc_q == CY_EULO) rdat_d = {8'h00, bus_din_i};
            else                  rdat_d[15:8] = bus_din_i;
          end
        end
      end
      PH_IDLE: if (idle_q != 2'd0) idle_d = idle_q - 2'd1;
      default: ;
    endcase
    if (boundary) begin
      if (flush_i && !hi_next) begin
        q_clr_o = 1'b1;
        flag_d  = 1'b0;
        pfa_d   = flush_addr_i;
        ph_d    = PH_IDLE;
        idle_d  = 2'd0;
      end else if (hi_next) begin
        ph_d   = PH_T1;
        cyc_d  = CY_EUHI;
        addr_d = addr_q + AW'(1);
      end else if (flag_q || !req_seen) begin
        flag_d = 1'b0;
        if (!q_full_i) begin
          ph_d   = PH_T1;
          cyc_d  = CY_PF;
          addr_d = pfa_q;
        end else begin
          ph_d   = PH_IDLE;
          idle_d = flag_q ? FORCED_IDLE_LAST : 2'd0;
        end
      end else begin
        ph_d   = PH_T1;
        cyc_d  = CY_EULO;
        addr_d = req_addr_i;
        wr_d   = req_write_i;
        word_d = req_word_i;
        wdat_d = req_wdata_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;  cyc_q <= CY_PF;  idle_q <= 2'd0;  flag_q <= 1'b0;
      pfa_q <= '0;  addr_q <= '0;  wr_q <= 1'b0;  word_q <= 1'b0;
      wdat_q <= '0;  rdat_q <= '0;  done_q <= 1'b0;
    end else begin
      ph_q <= ph_d;  cyc_q <= cyc_d;  idle_q <= idle_d;  flag_q <= flag_d;
      pfa_q <= pfa_d;  addr_q <= addr_d;  wr_q <= wr_d;  word_q <= word_d;
      wdat_q <= wdat_d;  rdat_q <= rdat_d;  done_q <= done_d;
    end
  end

  assign strobe      = (ph_q == PH_T2) || (ph_q == PH_T3);
  assign bus_rd_o    = strobe && ((cyc_q == CY_PF) || !wr_q);
  assign bus_wr_o    = strobe && (cyc_q != CY_PF) && wr_q;
  assign bus_dout_o  = (cyc_q == CY_EUHI) ? wdat_q[15:8] : wdat_q[7:0];
  assign bus_addr_o  = addr_q;
  assign bus_state_o = ph_q;
  assign q_push_o    = (ph_q == PH_T3) && (cyc_q == CY_PF);
  assign req_done_o  = done_q;
  assign req_rdata_o = rdat_q;

  a_r1_t1_to_t2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state_o == 3'd1) |=> (bus_state_o == 3'd2));
  a_r1_t2_to_t3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state_o == 3'd2) |=> (bus_state_o == 3'd3));
  a_r1_t3_to_t4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state_o == 3'd3) |=> (bus_state_o == 3'd4));
  a_r6_word_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_T4 && cyc_q == CY_EULO && word_q) |=>
      (bus_state_o == 3'd1 && bus_addr_o == $past(bus_addr_o) + AW'(1)));
  a_r4_three_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !flush_i && !hi_next && flag_q && q_full_i) |=>
      (bus_state_o == 3'd0) ##1 (bus_state_o == 3'd0) ##1 (bus_state_o == 3'd0));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_done_o |=> !req_done_o);
  a_r11_pf_keeps_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_T3 && cyc_q == CY_PF && !flag_q) |=> !flag_q);
endmodule

// File: rtl/busunit_arbiter.sv
module busunit_arbiter #(
  parameter int AW     = 20,
  parameter int QDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          req_done,
  output logic [15:0]   req_rdata,
  input  logic          q_pop,
  output logic          q_valid,
  output logic [7:0]    q_byte,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_dout,
  input  logic [7:0]    bus_din,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [2:0]    bus_state
);
  localparam int CW = $clog2(QDEPTH + 1);

  logic [1:0]    rst_pipe;
  logic          rst_core_n;
  logic [CW-1:0] q_count;
  logic          q_full, q_push, q_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  bpa_queue #(.DEPTH(QDEPTH), .CW(CW)) u_queue (
    .clk(clk), .rst_n(rst_core_n), .clr_i(q_clr), .push_i(q_push),
    .push_data_i(bus_din), .pop_i(q_pop), .head_o(q_byte),
    .count_o(q_count), .full_o(q_full)
  );

  bpa_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_core_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_word_i(req_word),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_done_o(req_done), .req_rdata_o(req_rdata),
    .flush_i(flush), .flush_addr_i(flush_addr),
    .q_count_i(q_count), .q_full_i(q_full), .q_push_o(q_push), .q_clr_o(q_clr),
    .bus_addr_o(bus_addr), .bus_dout_o(bus_dout), .bus_din_i(bus_din),
    .bus_rd_o(bus_rd), .bus_wr_o(bus_wr), .bus_state_o(bus_state)
  );

  assign q_valid = (q_count != '0);
endmodule

// File: tb/busunit_arbiter_bench.sv
`timescale 1ns/1ps
module busunit_arbiter_bench;
  localparam int AW = 20;

  typedef struct packed {
    logic        wr;
    logic        word;
    logic [19:0] addr;
    logic [15:0] data;  // expected read result, or write data
  } vec_t;

  localparam vec_t VTAB [5] = '{
    '{1'b0, 1'b0, 20'h08010, 16'h004A},
    '{1'b0, 1'b1, 20'h08020, 16'h7B7A},
    '{1'b1, 1'b0, 20'h08030, 16'h00C3},
    '{1'b1, 1'b1, 20'h080FF, 16'hBEEF},
    '{1'b0, 1'b1, 20'h081FF, 16'h5AA5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid, req_write, req_word, req_done, q_pop, q_valid, flush;
  logic          bus_rd, bus_wr;
  logic [AW-1:0] req_addr, flush_addr, bus_addr;
  logic [15:0]   req_wdata, req_rdata;
  logic [7:0]    q_byte, bus_dout, bus_din;
  logic [2:0]    bus_state;

  busunit_arbiter u_busunit_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_done(req_done), .req_rdata(req_rdata), .q_pop(q_pop),
    .q_valid(q_valid), .q_byte(q_byte), .flush(flush), .flush_addr(flush_addr),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_state(bus_state)
  );

  assign bus_din = bus_addr[7:0] ^ 8'h5A;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int log_n  = 0;
  logic [AW-1:0] log_addr [1024];
  logic          log_wr   [1024];
  logic [7:0]    log_dout [1024];
  int            log_cyc  [1024];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (bus_state == 3'd2 && log_n < 1024) begin
      log_addr[log_n] = bus_addr;
      log_wr[log_n]   = bus_wr;
      log_dout[log_n] = bus_dout;
      log_cyc[log_n]  = cyc;
      log_n = log_n + 1;
    end
    if (cyc == 20000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(negedge clk);
      #0.1;
    end
  endtask

  task automatic wait_done(output logic [15:0] rd);
    int k;
    k = 0;
    while (!req_done && k < 80) begin
      tick();
      k++;
    end
    chk(req_done, "R8 done pulse seen", 32'(req_done), 32'd1);
    rd = req_rdata;
  endtask

  task automatic drive_req(input logic w, input logic wd, input logic [AW-1:0] a,
                           input logic [15:0] d);
    req_write = w;  req_word = wd;  req_addr = a;  req_wdata = d;  req_valid = 1'b1;
  endtask

  initial begin
    logic [15:0] rd;
    int n0;
    req_valid = 0; req_write = 0; req_word = 0; req_addr = '0; req_wdata = '0;
    q_pop = 0; flush = 0; flush_addr = '0;
    tick(3);
    chk(bus_state == 3'd0, "R1 idle in reset", 32'(bus_state), 0);
    chk(!q_valid, "R10 empty in reset", 32'(q_valid), 0);
    chk(!req_done, "R8 no done in reset", 32'(req_done), 0);
    rst_n = 1'b1;
    tick(40);

    // R7: fill from address 0 with no gaps
    chk(log_n == 4, "R7 prefetch count", 32'(log_n), 4);
    for (int i = 0; i < 4; i++)
      chk(log_addr[i] == AW'(i) && !log_wr[i], "R7 prefetch address", 32'(log_addr[i]), 32'(i));
    for (int i = 1; i < 4; i++)
      chk(log_cyc[i] - log_cyc[i-1] == 4, "R7 back to back", 32'(log_cyc[i] - log_cyc[i-1]), 4);
    chk(q_valid && q_byte == 8'h5A, "R10 head byte", 32'(q_byte), 32'h5A);
    chk(bus_state == 3'd0, "R5 idle when full", 32'(bus_state), 0);

    // table of requests: R6, R8, R1 strobes
    for (int v = 0; v < 5; v++) begin
      int m;
      int idx0;
      int idx1;
      n0 = log_n;
      drive_req(VTAB[v].wr, VTAB[v].word, VTAB[v].addr, VTAB[v].data);
      wait_done(rd);
      req_valid = 1'b0;
      if (!VTAB[v].wr) chk(rd == VTAB[v].data, "R8 read data", 32'(rd), 32'(VTAB[v].data));
      tick();
      chk(!req_done, "R8 single pulse", 32'(req_done), 0);
      tick(12);
      m = 0; idx0 = 0; idx1 = 0;
      for (int j = n0; j < log_n; j++)
        if (log_addr[j][15]) begin
          if (m == 0) idx0 = j;
          if (m == 1) idx1 = j;
          m++;
        end
      chk(m == (VTAB[v].word ? 2 : 1), "R6 byte cycle count", 32'(m), VTAB[v].word ? 2 : 1);
      chk(log_addr[idx0] == VTAB[v].addr, "R6 low address", 32'(log_addr[idx0]), 32'(VTAB[v].addr));
      chk(log_wr[idx0] == VTAB[v].wr, "R1 strobe kind", 32'(log_wr[idx0]), 32'(VTAB[v].wr));
      if (VTAB[v].wr)
        chk(log_dout[idx0] == VTAB[v].data[7:0], "R6 low write byte", 32'(log_dout[idx0]), 32'(VTAB[v].data[7:0]));
      if (VTAB[v].word && m == 2) begin
        chk(log_addr[idx1] == VTAB[v].addr + AW'(1), "R6 high address", 32'(log_addr[idx1]), 32'(VTAB[v].addr + AW'(1)));
        chk(log_cyc[idx1] - log_cyc[idx0] == 4, "R6 no gap", 32'(log_cyc[idx1] - log_cyc[idx0]), 4);
        if (VTAB[v].wr)
          chk(log_dout[idx1] == VTAB[v].data[15:8], "R6 high write byte", 32'(log_dout[idx1]), 32'(VTAB[v].data[15:8]));
      end
    end

    // R2 / R5: request during one-clock idling starts on the next clock
    tick(10);
    drive_req(1'b0, 1'b0, 20'h08300, 16'h0);
    tick();
    chk(bus_state == 3'd1, "R2 R5 immediate T1", 32'(bus_state), 1);
    wait_done(rd);
    req_valid = 1'b0;
    chk(rd == 16'h005A, "R2 read data", 32'(rd), 32'h5A);
    tick(12);

    // R4: two byte reads with a full queue, 3 idle clocks between
    n0 = log_n;
    drive_req(1'b0, 1'b0, 20'h08400, 16'h0);
    wait_done(rd);
    chk(rd == 16'h005A, "R4 first read", 32'(rd), 32'h5A);
    req_addr = 20'h08401;
    tick();
    wait_done(rd);
    req_valid = 1'b0;
    chk(rd == 16'h005B, "R4 second read", 32'(rd), 32'h5B);
    tick(12);
    chk(log_n - n0 == 2, "R4 no prefetch between", 32'(log_n - n0), 2);
    chk(log_cyc[n0+1] - log_cyc[n0] == 7, "R4 spacing", 32'(log_cyc[n0+1] - log_cyc[n0]), 7);

    // R10: drain in order, then pop on empty while a byte lands
    q_pop = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk(q_valid && q_byte == (8'(i) ^ 8'h5A), "R10 fifo order", 32'(q_byte), 32'(8'(i) ^ 8'h5A));
      tick();
    end
    q_pop = 1'b0;
    chk(!q_valid, "R10 drained", 32'(q_valid), 0);
    q_pop = 1'b1;
    tick();
    q_pop = 1'b0;
    for (int k = 0; k < 20 && !q_valid; k++) tick();
    chk(q_valid && q_byte == 8'h5E, "R10 pop on empty ignored", 32'(q_byte), 32'h5E);
    tick(30);

    // R9: flush at a boundary, then an ignored flush inside a transfer
    n0 = log_n;
    flush_addr = 20'h00100;
    flush = 1'b1;
    tick();
    flush = 1'b0;
    chk(!q_valid, "R9 queue cleared", 32'(q_valid), 0);
    chk(bus_state == 3'd0, "R9 idle clock", 32'(bus_state), 0);
    tick();
    chk(bus_state == 3'd1, "R9 refetch starts", 32'(bus_state), 1);
    tick();
    flush_addr = 20'h00200;
    flush = 1'b1;
    tick();
    flush = 1'b0;
    tick(30);
    chk(log_n - n0 == 4, "R9 refill count", 32'(log_n - n0), 4);
    for (int i = 0; i < 4; i++)
      chk(log_addr[n0+i] == 20'h00100 + AW'(i), "R9 reload address", 32'(log_addr[n0+i]), 32'(20'h00100 + AW'(i)));
    chk(q_byte == 8'h5A, "R9 mid-transfer flush ignored", 32'(q_byte), 32'h5A);

    // R3 / R11: partly filled queue, request held across done
    flush_addr = 20'h00140;
    flush = 1'b1;
    tick();
    flush = 1'b0;
    for (int k = 0; k < 20 && !q_valid; k++) tick();
    tick();
    for (int k = 0; k < 20 && bus_state != 3'd4; k++) tick();
    n0 = log_n;
    drive_req(1'b0, 1'b0, 20'h08555, 16'h0);
    wait_done(rd);
    chk(rd == 16'h000F, "R3 first read", 32'(rd), 32'h0F);
    req_addr = 20'h08556;
    tick();
    wait_done(rd);
    req_valid = 1'b0;
    chk(rd == 16'h000C, "R3 second read", 32'(rd), 32'h0C);
    tick(12);
    chk(log_addr[n0-1] == 20'h00141, "R11 prior prefetch", 32'(log_addr[n0-1]), 32'h141);
    chk(log_cyc[n0] - log_cyc[n0-1] == 4, "R11 request not delayed", 32'(log_cyc[n0] - log_cyc[n0-1]), 4);
    chk(log_addr[n0] == 20'h08555, "R3 first transfer", 32'(log_addr[n0]), 32'h8555);
    chk(log_addr[n0+1] == 20'h00142, "R3 forced prefetch", 32'(log_addr[n0+1]), 32'h142);
    chk(log_addr[n0+2] == 20'h08556, "R3 second transfer", 32'(log_addr[n0+2]), 32'h8556);
    chk(log_cyc[n0+2] - log_cyc[n0] == 8, "R3 spacing", 32'(log_cyc[n0+2] - log_cyc[n0]), 8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule